// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a synchronous static RAM whose write data trails its command by the same two clock edges that a read needs to return data. Because both directions share one latency, a controller can issue reads and writes back to back in any order and the shared data bus never needs an idle turnaround cycle. Each word is split into four 9-bit byte lanes that can be written separately. The default depth is 1024 words so that the model stays small when elaborated. Setting `ADDR_W` to 16 gives the full 64K-word array.

Commands are captured on the rising clock edge. A load cycle takes a new address and operation from the pins. An advance cycle ignores the pins and continues the previous operation at the next address of a four-beat burst, stepping in linear or interleaved order. A single clock enable freezes the whole pipeline. Three chip enables deselect the device. A deselect acts through the same two-stage pipeline, so reads and writes already issued still complete.

The bidirectional data pin is split into `data_i`, `data_o` and the drive enable `data_oe_o`.

Top module: `late_write_sram`

## Requirements
- R1: While `rst_ni` is low and after it is released, `data_oe_o` is low, and the command pipeline holds no read or write.
- R2: A read is a load cycle with the device selected and `rw_i` high. Its word appears on `data_o`, with `data_oe_o` high, after the second enabled edge following the command edge, and it stays there until the next enabled edge.
- R3: A write is a load cycle with the device selected and `rw_i` low. The address and lane enables are captured on the command edge, and `data_i` is sampled on the second enabled edge after it.
- R4: Reads and writes may follow each other on consecutive edges in any order. A read issued on the edge after a write to the same address returns the newly written word.
- R5: `bw_ni[k]` low enables lane k, which is bits [9k+8:9k]. Lanes whose enable is high keep their old contents.
- R6: When `adv_i` is high, `addr_i`, the chip enables and `rw_i` are ignored. The previous operation (read, write or deselect) repeats at the next burst address, the upper address bits stay fixed, and `bw_ni` is still taken on every burst write edge.
- R7: Beat n of a burst (n = 0..3) has its low two address bits equal to (start + n) mod 4 when `burst_ilv_i` is 0, and to start XOR n when `burst_ilv_i` is 1.
- R8: On an edge where `cen_ni` is high, nothing changes: outputs hold, no burst step occurs, and `data_i` is not sampled. Stalled edges do not count toward the latencies of R2 and R3.
- R9: A load cycle with `ce1_ni` high, `ce2_i` low or `ce3_ni` high is a deselect. It performs no access, `data_oe_o` is low two enabled edges later, and operations issued earlier still complete.
- R10: `data_oe_o` is high only when the operation two enabled edges earlier was a read and `oe_ni` is low. `oe_ni` acts without a clock, and the result of a write never drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low; high stalls the pipeline |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| rw_i | input | 1 | High = read, low = write (load cycles only) |
| adv_i | input | 1 | High = continue burst, low = load from pins |
| burst_ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| bw_ni | input | LANES | Byte-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Output enable, active low |
| data_i | input | LANES*LANE_W | Write data from the bus |
| data_o | output | LANES*LANE_W | Read data to the bus |
| data_oe_o | output | 1 | Bus drive enable |

## Verification
The case that matters is a write committing its data on the same edge that an earlier read leaves the array, followed at once by a read of the address just written. The vector table sets up write, write, read, read, write, read on consecutive edges and compares each returned word with the value the table wrote. Stalls are then placed between a command and its data edge. These checks confirm that write sampling and read return both count enabled edges only, and that a held output does not move while the clock enable is high.

// File: rtl/late_write_sram_pkg.sv
package late_write_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low two address bits for beat n of a burst
  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] n,
                                           input logic       ilv);
    return ilv ? (start ^ n) : (start + n);
  endfunction

endpackage

// File: rtl/lws_burst_addr.sv
module lws_burst_addr
  import late_write_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;

  assign cnt_nx = cnt_q + 2'd1;
  assign addr_o = adv_i ? {base_q[ADDR_W-1:2], burst_lsb(base_q[1:0], cnt_nx, ilv_i)}
                        : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (adv_i) begin
        cnt_q <= cnt_nx;
      end else begin
        base_q <= addr_i;
        cnt_q  <= '0;
      end
    end
  end

endmodule

// File: rtl/lws_cmd_pipe.sv
module lws_cmd_pipe
  import late_write_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  bw_o
);

  op_e               op_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LANES-1:0]  bw_q   [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) op_q[k] <= OP_IDLE;
    end else if (en_i) begin
      op_q[0] <= op_i;
      for (int k = 1; k < DEPTH; k++) op_q[k] <= op_q[k-1];
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      addr_q[0] <= addr_i;
      bw_q[0]   <= bw_i;
      for (int k = 1; k < DEPTH; k++) begin
        addr_q[k] <= addr_q[k-1];
        bw_q[k]   <= bw_q[k-1];
      end
    end
  end

  assign op_o   = op_q[DEPTH-1];
  assign addr_o = addr_q[DEPTH-1];
  assign bw_o   = bw_q[DEPTH-1];

endmodule

// File: rtl/lws_array.sv
module lws_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORDS  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvld_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [WORDS];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (en_i && wr_i && bw_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           rd_q <= '0;
      else if (en_i && rd_i) rd_q <= mem[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rvld_o <= 1'b0;
    else if (en_i) rvld_o <= rd_i;
  end

endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import late_write_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int LAT    = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              rw_i,
  input  logic              adv_i,
  input  logic              burst_ilv_i,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);

  logic              en;
  logic              sel;
  op_e               cmd_op;
  op_e               last_op_q;
  logic [ADDR_W-1:0] cmd_addr;
  op_e               mem_op;
  logic [ADDR_W-1:0] mem_addr;
  logic [LANES-1:0]  mem_bw;
  logic              rd_vld;

  assign en  = ~cen_ni;
  assign sel = ~ce1_ni & ce2_i & ~ce3_ni;

  always_comb begin
    if (adv_i)     cmd_op = last_op_q;
    else if (!sel) cmd_op = OP_IDLE;
    else           cmd_op = rw_i ? OP_RD : OP_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_op_q <= OP_IDLE;
    else if (en)  last_op_q <= cmd_op;
  end

  lws_burst_addr #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .adv_i  (adv_i),
    .ilv_i  (burst_ilv_i),
    .addr_i (addr_i),
    .addr_o (cmd_addr)
  );

  lws_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .DEPTH(LAT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .op_i   (cmd_op),
    .addr_i (cmd_addr),
    .bw_i   (~bw_ni),
    .op_o   (mem_op),
    .addr_o (mem_addr),
    .bw_o   (mem_bw)
  );

  // write commit and read fetch share one stage, so no bypass is needed
  lws_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .wr_i    (mem_op == OP_WR),
    .rd_i    (mem_op == OP_RD),
    .addr_i  (mem_addr),
    .bw_i    (mem_bw),
    .wdata_i (data_i),
    .rdata_o (data_o),
    .rvld_o  (rd_vld)
  );

  assign data_oe_o = rd_vld & ~oe_ni;

endmodule

// File: rtl/late_write_sram_chk.sv
module late_write_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              ce3_ni,
  input logic              rw_i,
  input logic              adv_i,
  input logic              burst_ilv_i,
  input logic              oe_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [ADDR_W-1:0] cmd_addr
);

  logic sel_c, rd_ld, wr_ld, ds_ld;
  assign sel_c = ~ce1_ni & ce2_i & ~ce3_ni;
  assign rd_ld = ~adv_i & sel_c & rw_i;
  assign wr_ld = ~adv_i & sel_c & ~rw_i;
  assign ds_ld = ~adv_i & ~sel_c;

  p_rd_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && $past(rd_ld, 3) && !$past(cen_ni, 3) && !$past(cen_ni, 2)
     && !$past(cen_ni, 1) && !oe_ni) |-> data_oe_o);

  p_wr_no_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && $past(wr_ld, 3) && !$past(cen_ni, 3) && !$past(cen_ni, 2)
     && !$past(cen_ni, 1)) |-> !data_oe_o);

  p_desel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && $past(ds_ld, 3) && !$past(cen_ni, 3) && !$past(cen_ni, 2)
     && !$past(cen_ni, 1)) |-> !data_oe_o);

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> $stable(data_o));

  p_burst_linear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !cen_ni && !$past(cen_ni) && adv_i && !burst_ilv_i
     && (!$past(adv_i) || !$past(burst_ilv_i)))
    |-> cmd_addr[1:0] == $past(cmd_addr[1:0]) + 2'd1);

  p_burst_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !cen_ni && !$past(cen_ni) && adv_i)
    |-> cmd_addr[ADDR_W-1:2] == $past(cmd_addr[ADDR_W-1:2]));

endmodule

bind late_write_sram late_write_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/late_write_sram_tb.sv
module late_write_sram_tb;

  localparam int AW = 10;
  localparam int DW = 36;

  logic          clk_i = 1'b0;
  logic          rst_ni, cen_ni, ce1_ni, ce2_i, ce3_ni, rw_i, adv_i, burst_ilv_i, oe_ni;
  logic [3:0]    bw_ni;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] data_i, data_o;
  logic          data_oe_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  late_write_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9), .LAT(2)) u_dut (
    .clk_i, .rst_ni, .cen_ni, .ce1_ni, .ce2_i, .ce3_ni, .rw_i, .adv_i, .burst_ilv_i,
    .bw_ni, .addr_i, .oe_ni, .data_i, .data_o, .data_oe_o
  );

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [3:0]    bwn);
    logic [DW-1:0] r;
    r = old_w;
    for (int l = 0; l < 4; l++) if (!bwn[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [DW-1:0] wv(input int n);
    return 36'h9_0000_0000 + DW'(n) * 36'h1111;
  endfunction

  localparam logic [DW-1:0] D0 = 36'h1_2345_6789;
  localparam logic [DW-1:0] D1 = 36'hA_BCDE_F012;
  localparam logic [DW-1:0] D2 = 36'h5_5AA5_5AA5;
  localparam logic [DW-1:0] D3 = 36'hF_FFFF_FFFF;
  localparam logic [DW-1:0] DM = lane_merge(D0, D3, 4'b1010);
  localparam logic [DW-1:0] JK = 36'h3_C3C3_C3C3;

  typedef struct packed {
    logic          rd;
    logic          sel;
    logic [3:0]    bwn;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          eoe;
    logic [DW-1:0] ed;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 4'h0, 10'h010, JK, 1'b0, 36'h0},
    '{1'b0, 1'b1, 4'h0, 10'h011, JK, 1'b0, 36'h0},
    '{1'b1, 1'b1, 4'hF, 10'h010, D0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 4'hF, 10'h011, D1, 1'b0, 36'h0},
    '{1'b0, 1'b1, 4'h0, 10'h012, JK, 1'b1, D0},
    '{1'b1, 1'b1, 4'hF, 10'h012, JK, 1'b1, D1},
    '{1'b0, 1'b0, 4'hF, 10'h000, D2, 1'b0, 36'h0},
    '{1'b0, 1'b0, 4'hF, 10'h000, JK, 1'b1, D2},
    '{1'b0, 1'b1, 4'hA, 10'h010, JK, 1'b0, 36'h0},
    '{1'b0, 1'b0, 4'hF, 10'h000, JK, 1'b0, 36'h0},
    '{1'b1, 1'b1, 4'hF, 10'h010, D3, 1'b0, 36'h0},
    '{1'b0, 1'b0, 4'hF, 10'h000, JK, 1'b0, 36'h0},
    '{1'b0, 1'b0, 4'hF, 10'h000, JK, 1'b1, DM}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic check(input string req, input logic exp_oe, input logic [DW-1:0] exp_d);
    n_chk++;
    if (data_oe_o !== exp_oe || (exp_oe && data_o !== exp_d)) begin
      n_err++;
      $display("FAIL %s: oe=%b data=%h, expected oe=%b data=%h", req, data_oe_o, data_o,
               exp_oe, exp_d);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic drive(input logic rd, input logic sel, input logic adv, input logic ilv,
                       input logic [3:0] bwn, input logic [AW-1:0] addr,
                       input logic [DW-1:0] din);
    cen_ni = 1'b0; rw_i = rd; ce1_ni = ~sel; ce2_i = 1'b1; ce3_ni = 1'b0;
    adv_i = adv; burst_ilv_i = ilv; bw_ni = bwn; addr_i = addr; data_i = din;
  endtask

  task automatic stall_tick(input logic [DW-1:0] din);
    cen_ni = 1'b1; data_i = din;
    tick();
  endtask

  task automatic burst_rd(input logic [AW-1:0] start, input logic ilv, input string req,
                          input logic [DW-1:0] e0, input logic [DW-1:0] e1,
                          input logic [DW-1:0] e2, input logic [DW-1:0] e3);
    drive(1, 1, 0, ilv, 4'hF, start, JK); tick();
    drive(0, 0, 1, ilv, 4'h0, 10'h155, JK); tick();
    drive(0, 0, 1, ilv, 4'h0, 10'h2AA, JK); tick(); check(req, 1, e0);
    drive(0, 0, 1, ilv, 4'h0, 10'h155, JK); tick(); check(req, 1, e1);
    drive(1, 0, 0, ilv, 4'hF, 10'h000, JK); tick(); check(req, 1, e2);
    drive(1, 0, 0, ilv, 4'hF, 10'h000, JK); tick(); check(req, 1, e3);
  endtask

  initial begin
    repeat (10000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; oe_ni = 1'b0;
    drive(0, 0, 0, 0, 4'hF, '0, '0);
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 0, '0);
    rst_ni = 1'b1;
    tick();
    check("R1 after reset", 0, '0);

    // mixed read/write stream, no idle cycles
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].rd, TBL[i].sel, 0, 0, TBL[i].bwn, TBL[i].addr, TBL[i].din);
      tick();
      check((i == NV - 1) ? "R5 lane merge" : "R2 R3 R4 R10 stream", TBL[i].eoe, TBL[i].ed);
    end

    // burst write from 0x020, pins garbled during advance (R6)
    drive(0, 1, 0, 0, 4'h0, 10'h020, JK); tick();
    drive(1, 0, 1, 0, 4'h0, 10'h3FF, JK); tick();
    drive(1, 0, 1, 0, 4'h0, 10'h3FF, wv(0)); tick(); check("R10 write not driven", 0, '0);
    drive(1, 0, 1, 0, 4'h0, 10'h3FF, wv(1)); tick(); check("R6 R10 burst write", 0, '0);
    drive(1, 0, 0, 0, 4'hF, 10'h000, wv(2)); tick();
    drive(1, 0, 0, 0, 4'hF, 10'h000, wv(3)); tick();

    burst_rd(10'h022, 0, "R6 R7 linear", wv(2), wv(3), wv(0), wv(1));
    burst_rd(10'h021, 1, "R7 interleaved", wv(1), wv(0), wv(3), wv(2));

    // stalls between read command and return
    drive(1, 1, 0, 0, 4'hF, 10'h020, JK); tick();
    drive(1, 1, 0, 0, 4'hF, 10'h021, JK); tick(); check("R8 pre-stall", 0, '0);
    stall_tick(JK); check("R8 stall holds", 0, '0);
    stall_tick(JK);
    drive(0, 0, 0, 0, 4'hF, 10'h000, JK); tick(); check("R2 R8 read after stall", 1, wv(0));
    stall_tick(JK); check("R8 output held", 1, wv(0));
    drive(0, 0, 0, 0, 4'hF, 10'h000, JK); tick(); check("R8 second read", 1, wv(1));

    // stalls between write command and data edge
    drive(0, 1, 0, 0, 4'h0, 10'h030, JK); tick();
    stall_tick(JK);
    drive(0, 0, 0, 0, 4'hF, 10'h000, JK); tick();
    stall_tick(JK);
    drive(0, 0, 0, 0, 4'hF, 10'h000, D1); tick();
    drive(1, 1, 0, 0, 4'hF, 10'h030, JK); tick();
    drive(0, 0, 0, 0, 4'hF, 10'h000, JK); tick();
    drive(0, 0, 0, 0, 4'hF, 10'h000, JK); tick(); check("R3 R8 write data edge", 1, D1);

    // each chip enable alone deselects
    for (int k = 0; k < 3; k++) begin
      drive(0, 1, 0, 0, 4'h0, 10'h020, JK);
      ce1_ni = (k == 0); ce2_i = (k != 1); ce3_ni = (k == 2);
      tick();
      drive(1, 1, 0, 0, 4'hF, 10'h021, JK);
      ce1_ni = (k == 0); ce2_i = (k != 1); ce3_ni = (k == 2);
      tick();
      drive(1, 1, 0, 0, 4'hF, 10'h020, JK); tick();
      drive(0, 0, 0, 0, 4'hF, 10'h000, JK); tick(); check("R9 deselected read", 0, '0);
      drive(0, 0, 0, 0, 4'hF, 10'h000, JK); tick(); check("R9 deselected write", 1, wv(0));
    end

    // output enable gating
    drive(1, 1, 0, 0, 4'hF, 10'h021, JK); tick();
    drive(0, 0, 0, 0, 4'hF, 10'h000, JK); tick();
    drive(0, 0, 0, 0, 4'hF, 10'h000, JK); tick();
    oe_ni = 1'b1; #1; check("R10 oe off", 0, '0);
    oe_ni = 1'b0; #1; check("R10 oe on", 1, wv(1));

    finish_run();
  end

endmodule